// File: doc/BRIEF.md
# SPI Master Register and Interrupt Front End

This unit is the software-visible side of an SPI master. A host reaches it over a simple two-phase read/write bus (select, then enable) and uses it to set up the serial engine: clock mode, divisor code, chip-select pattern, manual chip-select and manual-start options, inter-word delay, idle count and transmit watermark. Clock polarity and phase are held in the configuration word but are only passed on to the engine when the controller is switched on. This keeps the idle clock level from moving while a transfer may be running.

The unit also runs a seven-source interrupt scheme. Four sources are one-cycle event pulses that latch into sticky status bits, and a host clears them by writing ones to the status address. Three sources are live levels that the status view follows directly. Enables are set and cleared through two separate write-only addresses and can be read back through a read-only mask view. A single interrupt line is high whenever any visible status bit is also enabled. Writes to the transmit address and reads from the receive address are not stored here. They are passed to the FIFO side of the engine as one-cycle push and pop strobes.

Top module: `spim_csr_unit`

## Requirements
- R1: After reset the configuration word reads 0x00003C09 (master on, divisor code 1, all four chip selects high), the on/off register reads 0, the mask reads 0, the watermark reads 1, the delay and idle count read 0, and `irq` is low.
- R2: The configuration word at offset 0x00 holds these fields: master at bit 0, polarity at bit 1, phase at bit 2, divisor code at bits 5:3, chip-select pattern at bits 13:10, manual chip-select at bit 14 and manual-start enable at bit 15. Every other bit reads as 0, including the start command at bit 16. The divisor and chip-select fields appear on `ctl_baud` and `ctl_ss`.
- R3: A write to offset 0x00 with bit 16 set drives `start_pulse` high during that access cycle only.
- R4: `ctl_cpol` and `ctl_cpha` take the stored polarity and phase only on a write of 1 to bit 0 of the on/off register (offset 0x14) while it holds 0. A configuration write, a repeated write of 1, or a write of 0 leaves them unchanged.
- R5: Writing ones to offset 0x08 sets the matching mask bits. Writing ones to offset 0x0C clears them. Zero bits in either write leave the mask unchanged. Offset 0x10 reads the mask, and reads of 0x08 and 0x0C return 0.
- R6: The event sources at status bits 0, 1, 2 and 6 (bit 1 is mode fault, bit 2 is transmit over-watermark) latch a one-cycle pulse. The bit stays set until a 1 is written to the same bit at offset 0x04. Zero bits in that write have no effect.
- R7: When an event pulse arrives in the same cycle as a write of 1 that clears its status bit, the bit remains set.
- R8: Status bits 3 (transmit full), 4 (receive not empty) and 5 follow their live inputs, and writing 1 to them at 0x04 has no effect.
- R9: `irq` is high exactly when some bit of (status AND mask) is 1.
- R10: A write to offset 0x1C pulses `tx_push` for the access cycle and presents bits 7:0 of the write data on `tx_byte`. A read of 0x1C returns 0.
- R11: A read of offset 0x20 pulses `rx_pop` for the access cycle and returns `rx_byte` in bits 7:0.
- R12: The delay word (0x18, 32 bits), the idle count (0x24, low 8 bits) and the watermark (0x28, low 8 bits) read back what was written, and an unmapped offset reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| psel | input | 1 | Bus select |
| penable | input | 1 | Bus access phase |
| pwrite | input | 1 | 1 for write, 0 for read |
| paddr | input | 8 | Byte offset |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, valid in the access phase |
| irq_src | input | 7 | Interrupt sources: pulses for event bits, levels for live bits |
| rx_byte | input | 8 | Head byte of the receive FIFO |
| tx_push | output | 1 | Push strobe to the transmit FIFO |
| tx_byte | output | 8 | Byte to push |
| rx_pop | output | 1 | Pop strobe to the receive FIFO |
| start_pulse | output | 1 | Manual start command |
| ctl_en | output | 1 | Controller on |
| ctl_master | output | 1 | Master mode |
| ctl_cpol | output | 1 | Applied clock polarity |
| ctl_cpha | output | 1 | Applied clock phase |
| ctl_baud | output | 3 | Divisor code |
| ctl_ss | output | 4 | Chip-select pattern |
| ctl_man_ss | output | 1 | Manual chip-select |
| ctl_man_start | output | 1 | Manual-start enable |
| ctl_delay | output | 32 | Delay word |
| ctl_idle | output | 8 | Idle count |
| ctl_wm | output | 8 | Transmit watermark |
| irq | output | 1 | Interrupt request |

## Verification
The one collision this unit must resolve is a new event pulse arriving in the cycle where the host's write-one-to-clear removes the same status bit. The bench first latches the event bit, then raises the same source bit again during the access phase of the clearing write. It then reads the status back and expects the bit to still be set. A second clear, with no event alongside it, must then read back zero, which shows that the clear path itself works.

// File: rtl/spim_csr_pkg.sv
package spim_csr_pkg;

   localparam logic [7:0] A_CFG  = 8'h00;
   localparam logic [7:0] A_STAT = 8'h04;
   localparam logic [7:0] A_IEN  = 8'h08;
   localparam logic [7:0] A_IDIS = 8'h0C;
   localparam logic [7:0] A_MASK = 8'h10;
   localparam logic [7:0] A_ON   = 8'h14;
   localparam logic [7:0] A_DLY  = 8'h18;
   localparam logic [7:0] A_TXD  = 8'h1C;
   localparam logic [7:0] A_RXD  = 8'h20;
   localparam logic [7:0] A_IDLE = 8'h24;
   localparam logic [7:0] A_WM   = 8'h28;

   localparam int CB_MASTER = 0;
   localparam int CB_CPOL   = 1;
   localparam int CB_CPHA   = 2;
   localparam int CB_BAUD   = 3;
   localparam int CB_SS     = 10;
   localparam int CB_MSS    = 14;
   localparam int CB_MSE    = 15;
   localparam int CB_GO     = 16;
   localparam int SS_W      = 4;
   localparam int BAUD_W    = 3;

   typedef enum logic [3:0] {
      RS_CFG, RS_STAT, RS_IEN, RS_IDIS, RS_MASK, RS_ON,
      RS_DLY, RS_TXD, RS_RXD, RS_IDLE, RS_WM, RS_NONE
   } reg_sel_e;

endpackage

// File: rtl/spim_csr_decode.sv
module spim_csr_decode
   import spim_csr_pkg::*;
#(
   parameter int ADDR_W = 8
) (
   input  logic [ADDR_W-1:0] addr,
   output reg_sel_e          sel
);
   generate
      if (ADDR_W < 8) begin : g_chk_aw
         $error("ADDR_W must be at least 8");
      end
   endgenerate

   always_comb begin
      case (addr)
         ADDR_W'(A_CFG):  sel = RS_CFG;
         ADDR_W'(A_STAT): sel = RS_STAT;
         ADDR_W'(A_IEN):  sel = RS_IEN;
         ADDR_W'(A_IDIS): sel = RS_IDIS;
         ADDR_W'(A_MASK): sel = RS_MASK;
         ADDR_W'(A_ON):   sel = RS_ON;
         ADDR_W'(A_DLY):  sel = RS_DLY;
         ADDR_W'(A_TXD):  sel = RS_TXD;
         ADDR_W'(A_RXD):  sel = RS_RXD;
         ADDR_W'(A_IDLE): sel = RS_IDLE;
         ADDR_W'(A_WM):   sel = RS_WM;
         default:         sel = RS_NONE;
      endcase
   end
endmodule

// File: rtl/spim_cfg_bank.sv
module spim_cfg_bank
   import spim_csr_pkg::*;
#(
   parameter int          DATA_W = 32,
   parameter int          IDLE_W = 8,
   parameter int          WM_W   = 8,
   parameter logic [7:0]  WM_RST = 8'd1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_cfg,
   input  logic              wr_on,
   input  logic              wr_dly,
   input  logic              wr_idle,
   input  logic              wr_wm,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] cfg_word,
   output logic              on_q,
   output logic [DATA_W-1:0] dly_q,
   output logic [IDLE_W-1:0] idle_q,
   output logic [WM_W-1:0]   wm_q,
   output logic              master,
   output logic              cpol_act,
   output logic              cpha_act,
   output logic [BAUD_W-1:0] baud,
   output logic [SS_W-1:0]   ss,
   output logic              man_ss,
   output logic              man_start_en,
   output logic              start_pulse
);
   generate
      if (DATA_W < CB_GO + 1) begin : g_chk_dw
         $error("DATA_W too narrow for the configuration word");
      end
      if (IDLE_W > DATA_W || WM_W > DATA_W) begin : g_chk_fw
         $error("field wider than the data bus");
      end
   endgenerate

   logic cpol_q, cpha_q;
   logic on_rise;

   assign on_rise = wr_on && wdata[0] && !on_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         master       <= 1'b1;
         cpol_q       <= 1'b0;
         cpha_q       <= 1'b0;
         baud         <= BAUD_W'(1);
         ss           <= '1;
         man_ss       <= 1'b0;
         man_start_en <= 1'b0;
      end else if (wr_cfg) begin
         master       <= wdata[CB_MASTER];
         cpol_q       <= wdata[CB_CPOL];
         cpha_q       <= wdata[CB_CPHA];
         baud         <= wdata[CB_BAUD +: BAUD_W];
         ss           <= wdata[CB_SS +: SS_W];
         man_ss       <= wdata[CB_MSS];
         man_start_en <= wdata[CB_MSE];
      end
   end

   // Mode reaches the engine only on an off-to-on transition
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cpol_act <= 1'b0;
         cpha_act <= 1'b0;
      end else if (on_rise) begin
         cpol_act <= cpol_q;
         cpha_act <= cpha_q;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         on_q   <= 1'b0;
         dly_q  <= '0;
         idle_q <= '0;
         wm_q   <= WM_W'(WM_RST);
      end else begin
         if (wr_on)   on_q   <= wdata[0];
         if (wr_dly)  dly_q  <= wdata;
         if (wr_idle) idle_q <= wdata[IDLE_W-1:0];
         if (wr_wm)   wm_q   <= wdata[WM_W-1:0];
      end
   end

   assign start_pulse = wr_cfg && wdata[CB_GO];

   always_comb begin
      cfg_word                      = '0;
      cfg_word[CB_MASTER]           = master;
      cfg_word[CB_CPOL]             = cpol_q;
      cfg_word[CB_CPHA]             = cpha_q;
      cfg_word[CB_BAUD +: BAUD_W]   = baud;
      cfg_word[CB_SS +: SS_W]       = ss;
      cfg_word[CB_MSS]              = man_ss;
      cfg_word[CB_MSE]              = man_start_en;
   end

   // R4: applied mode moves only on an off-to-on write
   p_mode_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_on && wdata[0] && !on_q) |=> $stable({cpol_act, cpha_act}));

endmodule

// File: rtl/spim_irq_bank.sv
module spim_irq_bank #(
   parameter int                 NUM_IRQ   = 7,
   parameter logic [NUM_IRQ-1:0] LEVEL_SRC = 7'b0111000,
   parameter bit                 IRQ_REG   = 1'b0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_IRQ-1:0] src,
   input  logic               wr_clr,
   input  logic               wr_set,
   input  logic               wr_dis,
   input  logic [NUM_IRQ-1:0] wbits,
   output logic [NUM_IRQ-1:0] status,
   output logic [NUM_IRQ-1:0] mask,
   output logic               irq
);
   generate
      if (NUM_IRQ < 5) begin : g_chk_n
         $error("NUM_IRQ must cover the fault and FIFO sources");
      end
   endgenerate

   logic [NUM_IRQ-1:0] stat_q;
   logic [NUM_IRQ-1:0] clr_vec;
   logic               any_hit;

   assign clr_vec = wr_clr ? wbits : '0;

   // New events take priority over a clear in the same cycle
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stat_q <= '0;
      else        stat_q <= ((stat_q & ~clr_vec) | src) & ~LEVEL_SRC;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      mask <= '0;
      else if (wr_set) mask <= mask | wbits;
      else if (wr_dis) mask <= mask & ~wbits;
   end

   assign status  = stat_q | (src & LEVEL_SRC);
   assign any_hit = |(status & mask);

   generate
      if (IRQ_REG) begin : g_irq_ff
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) irq <= 1'b0;
            else        irq <= any_hit;
         end
      end else begin : g_irq_comb
         assign irq = any_hit;
         // R9: nothing enabled means no request
         p_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
            (mask == '0) |-> !irq);
      end
   endgenerate

   // R6: a latched event survives any cycle that does not clear it
   p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((status & $past(status & ~clr_vec & ~LEVEL_SRC))
               == $past(status & ~clr_vec & ~LEVEL_SRC)));

   // R7: an arriving event is visible next cycle even under a clear
   p_evt_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (|(src & ~LEVEL_SRC)) |=> ((status & $past(src & ~LEVEL_SRC))
                                == $past(src & ~LEVEL_SRC)));

   // R5: set port raises, disable port lowers
   p_mask_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
      wr_set |=> ((mask & $past(wbits)) == $past(wbits)));
   p_mask_dis_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_dis && !wr_set) |=> ((mask & $past(wbits)) == '0));

endmodule

// File: rtl/spim_csr_unit.sv
module spim_csr_unit
   import spim_csr_pkg::*;
#(
   parameter int ADDR_W  = 8,
   parameter int DATA_W  = 32,
   parameter int NUM_IRQ = 7,
   parameter int IDLE_W  = 8,
   parameter int WM_W    = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               psel,
   input  logic               penable,
   input  logic               pwrite,
   input  logic [ADDR_W-1:0]  paddr,
   input  logic [DATA_W-1:0]  pwdata,
   output logic [DATA_W-1:0]  prdata,
   input  logic [NUM_IRQ-1:0] irq_src,
   input  logic [7:0]         rx_byte,
   output logic               tx_push,
   output logic [7:0]         tx_byte,
   output logic               rx_pop,
   output logic               start_pulse,
   output logic               ctl_en,
   output logic               ctl_master,
   output logic               ctl_cpol,
   output logic               ctl_cpha,
   output logic [BAUD_W-1:0]  ctl_baud,
   output logic [SS_W-1:0]    ctl_ss,
   output logic               ctl_man_ss,
   output logic               ctl_man_start,
   output logic [DATA_W-1:0]  ctl_delay,
   output logic [IDLE_W-1:0]  ctl_idle,
   output logic [WM_W-1:0]    ctl_wm,
   output logic               irq
);
   localparam logic [NUM_IRQ-1:0] LEVEL_SRC = NUM_IRQ'(7'b0111000);

   generate
      if (NUM_IRQ > DATA_W) begin : g_chk_irq
         $error("NUM_IRQ exceeds DATA_W");
      end
   endgenerate

   reg_sel_e           sel;
   logic               acc, wr, rd;
   logic [DATA_W-1:0]  cfg_word;
   logic [NUM_IRQ-1:0] status, mask;

   assign acc = psel && penable;
   assign wr  = acc && pwrite;
   assign rd  = acc && !pwrite;

   spim_csr_decode #(.ADDR_W(ADDR_W)) u_dec (
      .addr (paddr),
      .sel  (sel)
   );

   spim_cfg_bank #(
      .DATA_W (DATA_W),
      .IDLE_W (IDLE_W),
      .WM_W   (WM_W),
      .WM_RST (8'd1)
   ) u_cfg (
      .clk          (clk),
      .rst_n        (rst_n),
      .wr_cfg       (wr && sel == RS_CFG),
      .wr_on        (wr && sel == RS_ON),
      .wr_dly       (wr && sel == RS_DLY),
      .wr_idle      (wr && sel == RS_IDLE),
      .wr_wm        (wr && sel == RS_WM),
      .wdata        (pwdata),
      .cfg_word     (cfg_word),
      .on_q         (ctl_en),
      .dly_q        (ctl_delay),
      .idle_q       (ctl_idle),
      .wm_q         (ctl_wm),
      .master       (ctl_master),
      .cpol_act     (ctl_cpol),
      .cpha_act     (ctl_cpha),
      .baud         (ctl_baud),
      .ss           (ctl_ss),
      .man_ss       (ctl_man_ss),
      .man_start_en (ctl_man_start),
      .start_pulse  (start_pulse)
   );

   spim_irq_bank #(
      .NUM_IRQ   (NUM_IRQ),
      .LEVEL_SRC (LEVEL_SRC),
      .IRQ_REG   (1'b0)
   ) u_irq (
      .clk    (clk),
      .rst_n  (rst_n),
      .src    (irq_src),
      .wr_clr (wr && sel == RS_STAT),
      .wr_set (wr && sel == RS_IEN),
      .wr_dis (wr && sel == RS_IDIS),
      .wbits  (pwdata[NUM_IRQ-1:0]),
      .status (status),
      .mask   (mask),
      .irq    (irq)
   );

   assign tx_push = wr && sel == RS_TXD;
   assign tx_byte = pwdata[7:0];
   assign rx_pop  = rd && sel == RS_RXD;

   always_comb begin
      prdata = '0;
      if (rd) begin
         case (sel)
            RS_CFG:  prdata = cfg_word;
            RS_STAT: prdata = DATA_W'(status);
            RS_MASK: prdata = DATA_W'(mask);
            RS_ON:   prdata = DATA_W'(ctl_en);
            RS_DLY:  prdata = ctl_delay;
            RS_RXD:  prdata = DATA_W'(rx_byte);
            RS_IDLE: prdata = DATA_W'(ctl_idle);
            RS_WM:   prdata = DATA_W'(ctl_wm);
            default: prdata = '0;
         endcase
      end
   end

   // R10/R11: one bus access cannot both push and pop
   p_strobe_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !(tx_push && rx_pop));

   // R11: a pop only happens during a read access
   p_pop_rd_r11: assert property (@(posedge clk) disable iff (!rst_n)
      rx_pop |-> (psel && penable && !pwrite));

endmodule

// File: tb/spim_csr_unit_tb.sv
module spim_csr_unit_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
   logic [7:0]  paddr = '0;
   logic [31:0] pwdata = '0;
   logic [31:0] prdata;
   logic [6:0]  lvl_in = '0, evt_in = '0;
   logic [6:0]  irq_src;
   logic [7:0]  rx_byte = '0;
   logic        tx_push, rx_pop, start_pulse;
   logic [7:0]  tx_byte;
   logic        ctl_en, ctl_master, ctl_cpol, ctl_cpha, ctl_man_ss, ctl_man_start;
   logic [2:0]  ctl_baud;
   logic [3:0]  ctl_ss;
   logic [31:0] ctl_delay;
   logic [7:0]  ctl_idle, ctl_wm;
   logic        irq;

   int checks = 0, errors = 0;
   logic [31:0] exp_q[$];
   string       tag_q[$];
   logic        seen_push, seen_pop, seen_start;
   logic [7:0]  seen_byte;

   assign irq_src = lvl_in | evt_in;

   always #4 clk = ~clk;

   spim_csr_unit u_dut (
      .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
      .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .irq_src(irq_src),
      .rx_byte(rx_byte), .tx_push(tx_push), .tx_byte(tx_byte), .rx_pop(rx_pop),
      .start_pulse(start_pulse), .ctl_en(ctl_en), .ctl_master(ctl_master),
      .ctl_cpol(ctl_cpol), .ctl_cpha(ctl_cpha), .ctl_baud(ctl_baud), .ctl_ss(ctl_ss),
      .ctl_man_ss(ctl_man_ss), .ctl_man_start(ctl_man_start), .ctl_delay(ctl_delay),
      .ctl_idle(ctl_idle), .ctl_wm(ctl_wm), .irq(irq)
   );

   task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   // Monitor: samples the access phase at the falling edge
   always @(negedge clk) begin
      if (psel && penable) begin
         if (tx_push) begin seen_push = 1'b1; seen_byte = tx_byte; end
         if (rx_pop)      seen_pop   = 1'b1;
         if (start_pulse) seen_start = 1'b1;
         if (!pwrite) begin
            if (exp_q.size() == 0) begin
               errors++;
               $display("FAIL scoreboard: actual %h expected none", prdata);
            end else begin
               chk(prdata, exp_q.pop_front(), tag_q.pop_front());
            end
         end
      end
   end

   task automatic bus(input logic w, input logic [7:0] a, input logic [31:0] d,
                      input logic [6:0] ev);
      seen_push = 1'b0; seen_pop = 1'b0; seen_start = 1'b0; seen_byte = '0;
      @(posedge clk); #1;
      psel = 1'b1; pwrite = w; paddr = a; pwdata = d;
      @(posedge clk); #1;
      penable = 1'b1; evt_in = ev;
      @(posedge clk); #1;
      psel = 1'b0; penable = 1'b0; pwrite = 1'b0; evt_in = '0;
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      bus(1'b1, a, d, 7'h0);
   endtask

   task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
      exp_q.push_back(exp);
      tag_q.push_back(tag);
      bus(1'b0, a, 32'h0, 7'h0);
   endtask

   task automatic pulse(input logic [6:0] e);
      @(posedge clk); #1 evt_in = e;
      @(posedge clk); #1 evt_in = '0;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      // R1 reset state
      chk(irq, 0, "R1 irq");
      rd(8'h00, 32'h3C09, "R1 cfg");
      rd(8'h14, 0, "R1 on");
      rd(8'h10, 0, "R1 mask");
      rd(8'h28, 1, "R1 wm");
      rd(8'h18, 0, "R1 delay");
      rd(8'h24, 0, "R1 idle");
      rd(8'h04, 0, "R1 status");
      // R2 / R3
      wr(8'h00, 32'hFFFF_FFFF);
      chk(seen_start, 1, "R3 start on bit16");
      rd(8'h00, 32'h0000_FC3F, "R2 cfg mask");
      wr(8'h00, 32'h0000_2416);
      chk(seen_start, 0, "R3 no start");
      rd(8'h00, 32'h0000_2416, "R2 cfg readback");
      chk(ctl_baud, 2, "R2 baud");
      chk(ctl_ss, 4'h9, "R2 ss");
      // R4
      chk({ctl_cpol, ctl_cpha}, 2'b00, "R4 not applied yet");
      wr(8'h14, 1);
      chk({ctl_cpol, ctl_cpha}, 2'b11, "R4 applied on rise");
      rd(8'h14, 1, "R4 on readback");
      wr(8'h00, 32'h0000_2410);
      chk({ctl_cpol, ctl_cpha}, 2'b11, "R4 cfg write held");
      wr(8'h14, 1);
      chk({ctl_cpol, ctl_cpha}, 2'b11, "R4 no rise held");
      wr(8'h14, 0);
      chk({ctl_cpol, ctl_cpha}, 2'b11, "R4 off held");
      wr(8'h14, 1);
      chk({ctl_cpol, ctl_cpha}, 2'b00, "R4 reapplied");
      // R5
      wr(8'h08, 32'h16);
      rd(8'h10, 32'h16, "R5 set");
      wr(8'h08, 32'h01);
      rd(8'h10, 32'h17, "R5 set more");
      wr(8'h0C, 32'h06);
      rd(8'h10, 32'h11, "R5 disable");
      wr(8'h08, 32'h00);
      rd(8'h10, 32'h11, "R5 zero set");
      rd(8'h08, 0, "R5 en port reads 0");
      rd(8'h0C, 0, "R5 dis port reads 0");
      // R6
      pulse(7'h02);
      rd(8'h04, 32'h02, "R6 modf latched");
      pulse(7'h40);
      rd(8'h04, 32'h42, "R6 second latched");
      wr(8'h04, 32'h02);
      rd(8'h04, 32'h40, "R6 w1c");
      wr(8'h04, 32'h00);
      rd(8'h04, 32'h40, "R6 zero clear");
      chk(irq, 0, "R9 masked off");
      // R9
      wr(8'h08, 32'h40);
      chk(irq, 1, "R9 enabled event");
      wr(8'h04, 32'h40);
      chk(irq, 0, "R9 cleared");
      // R8
      @(posedge clk); #1 lvl_in = 7'h10;
      rd(8'h04, 32'h10, "R8 live level");
      chk(irq, 1, "R9 level irq");
      wr(8'h04, 32'h10);
      rd(8'h04, 32'h10, "R8 clear ignored");
      @(posedge clk); #1 lvl_in = 7'h00;
      rd(8'h04, 0, "R8 level drop");
      chk(irq, 0, "R9 level gone");
      // R7 collision
      pulse(7'h04);
      rd(8'h04, 32'h04, "R7 latched");
      bus(1'b1, 8'h04, 32'h04, 7'h04);
      rd(8'h04, 32'h04, "R7 event wins");
      wr(8'h04, 32'h04);
      rd(8'h04, 0, "R7 clear alone");
      // R10
      wr(8'h1C, 32'h0000_01A5);
      chk(seen_push, 1, "R10 push");
      chk(seen_byte, 8'hA5, "R10 byte");
      rd(8'h1C, 0, "R10 txd reads 0");
      chk(seen_push, 0, "R10 no push on read");
      // R11
      rx_byte = 8'h3C;
      rd(8'h20, 32'h3C, "R11 rx data");
      chk(seen_pop, 1, "R11 pop");
      // R12
      wr(8'h18, 32'hDEAD_BEEF);
      rd(8'h18, 32'hDEAD_BEEF, "R12 delay");
      wr(8'h24, 32'h1FF);
      rd(8'h24, 32'hFF, "R12 idle");
      wr(8'h28, 32'h37);
      rd(8'h28, 32'h37, "R12 wm");
      rd(8'h2C, 0, "R12 unmapped");
      repeat (2) @(posedge clk);
      if (exp_q.size() != 0) begin
         errors++;
         $display("FAIL scoreboard: actual %0d pending expected 0", exp_q.size());
      end
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule